// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit configuration and status words on a simple word-addressed read/write bus. A 12-bit byte address selects one word, and the two low address bits are ignored. A write-protection latch guards most words. The latch is set out of reset. A write to a dedicated "protect" word sets it, but only when the low half of the data matches one 16-bit key. A write to a dedicated "release" word clears it, but only when the low half matches a different key. Any other data written to either word leaves the latch as it was.

Each word has its own access rights: read-write, read-only, write-only or unmapped. A read that is not allowed is reported on the error strobe but still completes: a write-only word returns its last written value and an unmapped word returns zero. A write that is not allowed is discarded and reported. A write to the reset-control word with bit 0 set raises a one-cycle request for a system soft reset. The clock, PLL and pin functions that these words would drive are not part of the block.

Top module: `syscfg_regbank`

## Requirements
- R1: After reset the bank reads back as follows. The latch status word (byte 0x00C) reads 1. The three PLL control words (0x100, 0x104, 0x108) read 0x0001A008. The PLL status word (0x10C) reads 0x0000003F. The three PLL config words (0x110, 0x114, 0x118) read 0x00014000. The boot-mode word (0x25C) reads BOOT_MODE. The identity word (0x530) reads ID_CODE.
- R2: A write to byte 0x004 whose data bits [15:0] equal 0x767B sets the latch, so that 0x00C reads 1. Any other data has no effect on the latch and raises no error.
- R3: A write to byte 0x008 whose data bits [15:0] equal 0xDF0D clears the latch, so that 0x00C reads 0. Any other data has no effect on the latch and raises no error.
- R4: While the latch is set, a write to a read-write word other than 0x000 is discarded, and the error strobe is raised.
- R5: Word 0x000 accepts writes whether or not the latch is set. It stores only bit 0 of the data.
- R6: A write to a read-only word (0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530) or to an unmapped address is discarded and raises the error strobe. This applies in either latch state.
- R7: A read of a write-only word (0x004, 0x008, 0x60C, 0x614) raises the error strobe and returns the last value written to that word. A read of an unmapped address raises the error strobe and returns zero.
- R8: With the latch clear, a write to 0x200 stores the data. If data bit 0 is 1, the soft-reset output is high for exactly the one cycle after that write. If bit 0 is 0, or if the latch is set, the soft-reset output stays low.
- R9: Read data and the read-valid flag appear in the cycle after the read strobe. Address bits [1:0] do not affect which word is selected.
- R10: When a read and a write to the same word are issued in the same cycle, the read returns the value the word held before that write, and the write takes effect.
- R11: The error strobe is high for one cycle only, in the cycle after the offending strobe. It is low after a legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address; bits [1:0] are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | High in the cycle after a read strobe |
| bus_err_o | output | 1 | One-cycle strobe for an illegal access |
| soft_rst_o | output | 1 | One-cycle soft-reset request |

## Verification
A read and a write to the same word can arrive in the same cycle. In that case the stored-word update and the read data path both act on one clock edge. The bench issues both strobes together on an unlocked PLL control word. It expects the old contents on the read data, and the new contents on a later read. Key-latch changes and the write gate also meet on one edge. This is checked by writing a protected word in the first access after a release or a protect, and judging the result by the error strobe and by read-back.

// File: rtl/syscfg_pkg.sv
// Package: shared constants, slot map and decode types for the register bank.
// Assumes 4 KiB of byte address space holding 32-bit words.
package syscfg_pkg;

    localparam int WORD_IDX_W = 10;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;

    localparam int NUM_PLL    = 3;
    localparam int NUM_THR    = 4;
    localparam int THR_STRIDE = 4;

    // Word indices (byte offset / 4)
    localparam int W_CTL0     = 'h000;
    localparam int W_PROTECT  = 'h001;
    localparam int W_RELEASE  = 'h002;
    localparam int W_LSTAT    = 'h003;
    localparam int W_PLLC0    = 'h040;
    localparam int W_PLLST    = 'h043;
    localparam int W_PLLF0    = 'h044;
    localparam int W_THR0     = 'h05F;
    localparam int W_RSTC     = 'h080;
    localparam int W_BOOT     = 'h097;
    localparam int W_IDC      = 'h14C;
    localparam int W_CAL      = 'h183;
    localparam int W_REF      = 'h185;

    // Storage slots
    localparam int SL_CTL0    = 0;
    localparam int SL_PROTECT = 1;
    localparam int SL_RELEASE = 2;
    localparam int SL_PLLC0   = 3;
    localparam int SL_PLLF0   = SL_PLLC0 + NUM_PLL;
    localparam int SL_RSTC    = SL_PLLF0 + NUM_PLL;
    localparam int SL_CAL     = SL_RSTC + 1;
    localparam int SL_REF     = SL_CAL + 1;
    localparam int NSLOT      = SL_REF + 1;
    localparam int SLOT_W     = $clog2(NSLOT);

    localparam logic [DATA_W-1:0] PLLC_RST  = 32'h0001_A008;
    localparam logic [DATA_W-1:0] PLLF_RST  = 32'h0001_4000;
    localparam logic [DATA_W-1:0] PLLST_VAL = 32'h0000_003F;
    localparam logic [DATA_W-1:0] THR_VAL   = 32'h0001_0000;

    typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;
    typedef enum logic [2:0] {RO_NONE, RO_LSTAT, RO_PLLST, RO_THR, RO_BOOT, RO_IDC} ro_e;

    typedef struct packed {
        acc_e              acc;
        logic [SLOT_W-1:0] slot;
        ro_e               ro;
        logic              exempt;   // writable regardless of the latch
        logic              is_prot;
        logic              is_rel;
        logic              is_rstc;
    } dec_t;

    // Reset value of one storage slot
    function automatic logic [DATA_W-1:0] slot_default(input int i);
        if (i >= SL_PLLC0 && i < SL_PLLC0 + NUM_PLL) return PLLC_RST;
        if (i >= SL_PLLF0 && i < SL_PLLF0 + NUM_PLL) return PLLF_RST;
        return '0;
    endfunction

    // Bits a slot keeps from a write
    function automatic logic [DATA_W-1:0] slot_mask(input int i);
        if (i == SL_CTL0) return {{(DATA_W-1){1'b0}}, 1'b1};
        return '1;
    endfunction

endpackage

// File: rtl/syscfg_decode.sv
// Module: address decoder. Maps a word index to access rights, a storage slot
// or a read-only source, and flags for the special words. Purely combinational.
module syscfg_decode
    import syscfg_pkg::*;
(
    input  logic [WORD_IDX_W-1:0] widx_i,
    output dec_t                  dec_o
);

    // Classify the word index
    always_comb begin
        int w;
        w = int'(widx_i);
        dec_o = '{acc: ACC_NONE, slot: '0, ro: RO_NONE, exempt: 1'b0,
                  is_prot: 1'b0, is_rel: 1'b0, is_rstc: 1'b0};
        if (w == W_CTL0) begin
            dec_o.acc = ACC_RW; dec_o.slot = SLOT_W'(SL_CTL0); dec_o.exempt = 1'b1;
        end else if (w == W_PROTECT) begin
            dec_o.acc = ACC_WO; dec_o.slot = SLOT_W'(SL_PROTECT);
            dec_o.exempt = 1'b1; dec_o.is_prot = 1'b1;
        end else if (w == W_RELEASE) begin
            dec_o.acc = ACC_WO; dec_o.slot = SLOT_W'(SL_RELEASE);
            dec_o.exempt = 1'b1; dec_o.is_rel = 1'b1;
        end else if (w == W_LSTAT) begin
            dec_o.acc = ACC_RO; dec_o.ro = RO_LSTAT;
        end else if (w >= W_PLLC0 && w < W_PLLC0 + NUM_PLL) begin
            dec_o.acc = ACC_RW; dec_o.slot = SLOT_W'(SL_PLLC0 + (w - W_PLLC0));
        end else if (w == W_PLLST) begin
            dec_o.acc = ACC_RO; dec_o.ro = RO_PLLST;
        end else if (w >= W_PLLF0 && w < W_PLLF0 + NUM_PLL) begin
            dec_o.acc = ACC_RW; dec_o.slot = SLOT_W'(SL_PLLF0 + (w - W_PLLF0));
        end else if (w == W_RSTC) begin
            dec_o.acc = ACC_RW; dec_o.slot = SLOT_W'(SL_RSTC); dec_o.is_rstc = 1'b1;
        end else if (w == W_BOOT) begin
            dec_o.acc = ACC_RO; dec_o.ro = RO_BOOT;
        end else if (w == W_IDC) begin
            dec_o.acc = ACC_RO; dec_o.ro = RO_IDC;
        end else if (w == W_CAL) begin
            dec_o.acc = ACC_WO; dec_o.slot = SLOT_W'(SL_CAL);
        end else if (w == W_REF) begin
            dec_o.acc = ACC_WO; dec_o.slot = SLOT_W'(SL_REF);
        end else begin
            for (int t = 0; t < NUM_THR; t++) begin
                if (w == W_THR0 + t * THR_STRIDE) begin
                    dec_o.acc = ACC_RO; dec_o.ro = RO_THR;
                end
            end
        end
    end

endmodule

// File: rtl/syscfg_lock.sv
// Module: write-protection latch. Set out of reset. A protect write with the
// matching key sets it; a release write with the matching key clears it.
// Assumes the two write flags are never high together (distinct addresses).
module syscfg_lock
    import syscfg_pkg::*;
#(
    parameter logic [KEY_W-1:0] PROTECT_KEY = 16'h767B,
    parameter logic [KEY_W-1:0] RELEASE_KEY = 16'hDF0D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_wr_i,
    input  logic             rel_wr_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             locked_o
);

    logic locked_q;

    // Latch update on a key match; other data leaves it unchanged
    always_ff @(posedge clk) begin
        if (!rst_n)                                locked_q <= 1'b1;
        else if (prot_wr_i && key_i == PROTECT_KEY) locked_q <= 1'b1;
        else if (rel_wr_i && key_i == RELEASE_KEY)  locked_q <= 1'b0;
    end

    assign locked_o = locked_q;

endmodule

// File: rtl/syscfg_store.sv
// Module: storage slots with per-slot reset values and write masks.
// Assumes at most one slot is written per cycle.
module syscfg_store
    import syscfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [SLOT_W-1:0]              slot_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [NSLOT-1:0][DATA_W-1:0]   slots_o
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_V = slot_default(g);
        localparam logic [DATA_W-1:0] MASK  = slot_mask(g);
        logic [DATA_W-1:0] q;

        // One slot: reset value, masked write on select
        always_ff @(posedge clk) begin
            if (!rst_n)                              q <= RST_V;
            else if (wr_i && slot_i == SLOT_W'(g))   q <= wdata_i & MASK;
        end

        assign slots_o[g] = q;
    end

endmodule

// File: rtl/syscfg_regbank.sv
// Module: top of the key-locked register bank. Decodes the bus, gates writes
// by access rights and the latch, and registers read data, error and soft-reset.
// Assumes single-word aligned accesses; address bits [1:0] are ignored.
module syscfg_regbank
    import syscfg_pkg::*;
#(
    parameter logic [KEY_W-1:0]  PROTECT_KEY = 16'h767B,
    parameter logic [KEY_W-1:0]  RELEASE_KEY = 16'hDF0D,
    parameter logic [DATA_W-1:0] ID_CODE     = 32'h1A2B_3C4D,
    parameter logic [DATA_W-1:0] BOOT_MODE   = 32'h0000_0001,
    localparam int               ADDR_W      = WORD_IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              bus_err_o,
    output logic              soft_rst_o
);

    dec_t                         dec;
    logic                         locked;
    logic                         wr_commit;
    logic                         wr_bad;
    logic                         rd_bad;
    logic [DATA_W-1:0]            rd_word;
    logic [NSLOT-1:0][DATA_W-1:0] slots;
    logic [DATA_W-1:0]            rdata_q;
    logic                         rvalid_q;
    logic                         err_q;
    logic                         srst_q;
    logic                         unused_lsb;

    assign unused_lsb = ^bus_addr_i[1:0];

    syscfg_decode u_dec (
        .widx_i (bus_addr_i[ADDR_W-1:2]),
        .dec_o  (dec)
    );

    syscfg_lock #(
        .PROTECT_KEY (PROTECT_KEY),
        .RELEASE_KEY (RELEASE_KEY)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_wr_i (bus_wr_i && dec.is_prot),
        .rel_wr_i  (bus_wr_i && dec.is_rel),
        .key_i     (bus_wdata_i[KEY_W-1:0]),
        .locked_o  (locked)
    );

    // Write gate: writable rights, and either exempt or unlocked
    always_comb begin
        wr_commit = bus_wr_i && (dec.acc == ACC_RW || dec.acc == ACC_WO)
                    && (dec.exempt || !locked);
        wr_bad    = bus_wr_i && !wr_commit;
        rd_bad    = bus_rd_i && (dec.acc == ACC_WO || dec.acc == ACC_NONE);
    end

    syscfg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_commit),
        .slot_i  (dec.slot),
        .wdata_i (bus_wdata_i),
        .slots_o (slots)
    );

    // Read source select: constant/status sources, stored slots, or zero
    always_comb begin
        rd_word = '0;
        if (dec.acc == ACC_RO) begin
            unique case (dec.ro)
                RO_LSTAT: rd_word = {{(DATA_W-1){1'b0}}, locked};
                RO_PLLST: rd_word = PLLST_VAL;
                RO_THR:   rd_word = THR_VAL;
                RO_BOOT:  rd_word = BOOT_MODE;
                RO_IDC:   rd_word = ID_CODE;
                default:  rd_word = '0;
            endcase
        end else if (dec.acc != ACC_NONE) begin
            rd_word = slots[dec.slot];
        end
    end

    // Output registers: read data, read valid, error strobe, soft-reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            srst_q   <= 1'b0;
        end else begin
            if (bus_rd_i) rdata_q <= rd_word;
            rvalid_q <= bus_rd_i;
            err_q    <= wr_bad || rd_bad;
            srst_q   <= wr_commit && dec.is_rstc && bus_wdata_i[0];
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;
    assign bus_err_o    = err_q;
    assign soft_rst_o   = srst_q;

endmodule

// File: rtl/syscfg_regbank_chk.sv
// Module: property checker for the register bank, bound to the top module.
module syscfg_regbank_chk
    import syscfg_pkg::*;
#(
    parameter logic [KEY_W-1:0] PROTECT_KEY = 16'h767B,
    parameter logic [KEY_W-1:0] RELEASE_KEY = 16'hDF0D
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr_i,
    input logic                  bus_rd_i,
    input logic [WORD_IDX_W+1:0] bus_addr_i,
    input logic [DATA_W-1:0]     bus_wdata_i,
    input logic                  bus_rvalid_o,
    input logic                  bus_err_o,
    input logic                  soft_rst_o,
    input logic                  locked
);

    logic [WORD_IDX_W-1:0] w;
    assign w = bus_addr_i[WORD_IDX_W+1:2];

    p_protect_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && w == WORD_IDX_W'(W_PROTECT) && bus_wdata_i[KEY_W-1:0] == PROTECT_KEY)
        |=> locked);

    p_latch_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && (w == WORD_IDX_W'(W_PROTECT) || w == WORD_IDX_W'(W_RELEASE)))
        |=> $stable(locked));

    p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && w == WORD_IDX_W'(W_RELEASE) && bus_wdata_i[KEY_W-1:0] == RELEASE_KEY)
        |=> !locked);

    p_locked_write_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && locked && w == WORD_IDX_W'(W_PLLC0)) |=> bus_err_o);

    p_ro_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && w == WORD_IDX_W'(W_PLLST)) |=> bus_err_o);

    p_srst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    p_srst_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && locked) |=> !soft_rst_o);

    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);

    p_err_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_i && !bus_rd_i) |=> !bus_err_o);

endmodule

bind syscfg_regbank syscfg_regbank_chk #(
    .PROTECT_KEY (PROTECT_KEY),
    .RELEASE_KEY (RELEASE_KEY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_i     (bus_wr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_err_o    (bus_err_o),
    .soft_rst_o   (soft_rst_o),
    .locked       (locked)
);

// File: tb/syscfg_regbank_tb.sv
`timescale 1ns/1ps
module syscfg_regbank_tb;

    localparam logic [31:0] ID_EXP   = 32'h1A2B_3C4D;
    localparam logic [31:0] BOOT_EXP = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, err, srst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    syscfg_regbank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .bus_err_o    (err),
        .soft_rst_o   (srst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             output logic e, output logic s);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        e = err; s = srst;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata; e = err;
        chk("R9 rvalid", {31'b0, rvalid}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        chk("R1 err idle", {31'b0, err}, 0);
        chk("R8 srst idle", {31'b0, srst}, 0);
        bus_read(12'h00C, d, e); chk("R1 lock status", d, 1); chk("R1 ro read err", {31'b0, e}, 0);
        bus_read(12'h100, d, e); chk("R1 pll ctrl0", d, 32'h0001_A008);
        bus_read(12'h108, d, e); chk("R1 pll ctrl2", d, 32'h0001_A008);
        bus_read(12'h10C, d, e); chk("R1 pll status", d, 32'h3F);
        bus_read(12'h114, d, e); chk("R1 pll cfg1", d, 32'h0001_4000);
        bus_read(12'h25C, d, e); chk("R1 boot mode", d, BOOT_EXP);
        bus_read(12'h530, d, e); chk("R1 id code", d, ID_EXP);
    endtask

    task automatic t_locked_writes;
        logic [31:0] d; logic e, s;
        bus_write(12'h104, 32'h1234_5678, e, s); chk("R4 locked write err", {31'b0, e}, 1);
        @(negedge clk); chk("R11 err one cycle", {31'b0, err}, 0);
        bus_read(12'h104, d, e); chk("R4 locked write discarded", d, 32'h0001_A008);
        bus_write(12'h200, 32'h1, e, s); chk("R8 locked rstc err", {31'b0, e}, 1);
        chk("R8 locked no srst", {31'b0, s}, 0);
    endtask

    task automatic t_ctl0;
        logic [31:0] d; logic e, s;
        bus_write(12'h000, 32'hFFFF_FFFE, e, s); chk("R5 ctl0 write err", {31'b0, e}, 0);
        bus_read(12'h000, d, e); chk("R5 ctl0 bit0 only", d, 0);
        bus_write(12'h000, 32'h3, e, s);
        bus_read(12'h000, d, e); chk("R5 ctl0 while locked", d, 1);
    endtask

    task automatic t_release;
        logic [31:0] d; logic e, s;
        bus_write(12'h008, 32'h0000_DF0C, e, s); chk("R3 bad key no err", {31'b0, e}, 0);
        bus_read(12'h00C, d, e); chk("R3 bad key keeps lock", d, 1);
        bus_write(12'h008, 32'hABCD_DF0D, e, s); chk("R3 good key no err", {31'b0, e}, 0);
        bus_read(12'h00C, d, e); chk("R3 released", d, 0);
    endtask

    task automatic t_rw;
        logic [31:0] d; logic e, s;
        bus_write(12'h104, 32'h1234_5678, e, s); chk("R11 legal write no err", {31'b0, e}, 0);
        bus_read(12'h104, d, e); chk("R9 readback", d, 32'h1234_5678);
        chk("R11 legal read no err", {31'b0, e}, 0);
        bus_read(12'h107, d, e); chk("R9 low bits ignored", d, 32'h1234_5678);
    endtask

    task automatic t_illegal;
        logic [31:0] d; logic e, s;
        bus_write(12'h10C, 32'h0, e, s); chk("R6 ro write err", {31'b0, e}, 1);
        bus_read(12'h10C, d, e); chk("R6 ro unchanged", d, 32'h3F);
        bus_write(12'h18C, 32'h0, e, s); chk("R6 thr status write err", {31'b0, e}, 1);
        bus_write(12'h800, 32'hDEAD_BEEF, e, s); chk("R6 unmapped write err", {31'b0, e}, 1);
        bus_read(12'h800, d, e); chk("R7 unmapped read zero", d, 0);
        chk("R7 unmapped read err", {31'b0, e}, 1);
        bus_write(12'h60C, 32'h55, e, s); chk("R7 wo write ok", {31'b0, e}, 0);
        bus_read(12'h60C, d, e); chk("R7 wo read data", d, 32'h55);
        chk("R7 wo read err", {31'b0, e}, 1);
        bus_read(12'h008, d, e); chk("R7 release word stored", d, 32'hABCD_DF0D);
    endtask

    task automatic t_soft_reset;
        logic [31:0] d; logic e, s;
        bus_write(12'h200, 32'h5, e, s); chk("R8 srst pulse", {31'b0, s}, 1);
        @(negedge clk); chk("R8 srst single cycle", {31'b0, srst}, 0);
        bus_read(12'h200, d, e); chk("R8 rstc stored", d, 32'h5);
        bus_write(12'h200, 32'h2, e, s); chk("R8 bit0 clear no srst", {31'b0, s}, 0);
    endtask

    task automatic t_simul;
        logic [31:0] d; logic e;
        @(negedge clk);
        wr = 1'b1; rd = 1'b1; addr = 12'h108; wdata = 32'hCAFE_0001;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R10 read sees old", rdata, 32'h0001_A008);
        bus_read(12'h108, d, e); chk("R10 write landed", d, 32'hCAFE_0001);
    endtask

    task automatic t_protect;
        logic [31:0] d; logic e, s;
        bus_write(12'h004, 32'h0000_767A, e, s); chk("R2 bad key no err", {31'b0, e}, 0);
        bus_write(12'h100, 32'h0000_0111, e, s); chk("R2 still unlocked", {31'b0, e}, 0);
        bus_write(12'h004, 32'hFFFF_767B, e, s);
        bus_read(12'h00C, d, e); chk("R2 protected", d, 1);
        bus_write(12'h100, 32'h0000_0222, e, s); chk("R4 err after protect", {31'b0, e}, 1);
        bus_read(12'h100, d, e); chk("R4 value kept", d, 32'h0000_0111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_writes();
        t_ctl0();
        t_release();
        t_rw();
        t_illegal();
        t_soft_reset();
        t_simul();
        t_protect();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule